// File: doc/BRIEF.md
# Programmable-Resolution Time Tag Counter

This block keeps a 16-bit time stamp for a serial bus controller or remote terminal. In timed mode the count advances once per period of a selectable resolution. That period is counted off a single-cycle enable that pulses once per microsecond. In self-test mode the count instead advances by one on each software step strobe. A host port can overwrite the count at any time, and the present value is always visible on the count output.

The bus-side protocol logic drives several event strobes into the block. A synchronize command without data can zero the count. A synchronize command with data can load the command's data word. A message-complete strobe latches the present count, which the descriptor writer then stores as the message's time-tag word. When rollover reporting is enabled, an increment from FFFF to 0000 sets a sticky status bit. The interrupt request is that bit gated by its mask.

Top module: `time_tag_unit`

## Requirements
- R1: While reset is held and in the first cycle after it, count_o, capture_o, capture_vld_o, roll_stat_o and irq_o are all zero.
- R2: In timed mode with the microsecond enable held high, the count advances once every 2, 4, 8, 16, 32 or 64 enable pulses for res_sel_i codes 0 to 5 respectively; codes 6 and 7 behave as 64.
- R3: Any change of res_sel_i restarts the prescaler, so the first increment after the change needs a full period of the new resolution.
- R4: A host write (host_wr_i) makes count_o equal host_wdata_i in the next cycle, and it wins over a sync clear, a sync load and an increment in the same cycle.
- R5: sync_clr_i zeroes the count in the next cycle when clr_en_i is high; when clr_en_i is low it has no effect on count_o.
- R6: sync_load_i loads sync_data_i in the next cycle when load_en_i is high, and it is ignored when load_en_i is low. If both sync events are enabled in one cycle, the clear wins.
- R7: With sw_mode_i high, timed ticks are ignored and each cycle with sw_step_i high adds exactly one to the count.
- R8: When msg_done_i is high in cycle N, capture_o holds the count_o value of cycle N from cycle N+1 on, and capture_vld_o is high in cycle N+1 only, unless another capture follows.
- R9: An increment from FFFF to 0000 while roll_en_i is high sets roll_stat_o in the next cycle. With roll_en_i low, the status is not set.
- R10: roll_stat_o stays set until a cycle with stat_clr_i high clears it. A rollover in the same cycle as the clear wins, and the bit stays set.
- R11: irq_o equals roll_stat_o ANDed with irq_mask_i, with no added delay.
- R12: Reaching zero through a host write or a sync event never sets roll_stat_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| us_tick_i | input | 1 | One-cycle enable, once per microsecond |
| res_sel_i | input | 3 | Resolution code (0=2 us ... 5=64 us, 6/7=64 us) |
| sw_mode_i | input | 1 | Selects software-step mode |
| sw_step_i | input | 1 | Software increment strobe |
| host_wr_i | input | 1 | Host write strobe |
| host_wdata_i | input | 16 | Host write data |
| sync_clr_i | input | 1 | Synchronize-without-data event |
| clr_en_i | input | 1 | Enables the sync clear |
| sync_load_i | input | 1 | Synchronize-with-data event |
| load_en_i | input | 1 | Enables the sync load |
| sync_data_i | input | 16 | Data word of the synchronize command |
| msg_done_i | input | 1 | Message-complete capture strobe |
| roll_en_i | input | 1 | Enables rollover status setting |
| stat_clr_i | input | 1 | Write-one-to-clear strobe for the status |
| irq_mask_i | input | 1 | Interrupt mask enable |
| count_o | output | 16 | Present count |
| capture_o | output | 16 | Count latched at the last message completion |
| capture_vld_o | output | 1 | One-cycle pulse after a capture |
| roll_stat_o | output | 1 | Sticky rollover status |
| irq_o | output | 1 | Interrupt request |

## Verification
Every cycle the assertions check that a host write lands in the next cycle and that a capture records the prior count. They also check that the status stays set until it is cleared and that a masked or unset status never raises the request. Finally they check that a frozen software-mode count holds still and that a wrap happens only from FFFF. The resolution periods, the prescaler restart on a code change, and the sync priorities and enables need stimulus sequences to show. So do the cases where a load to zero must leave the status alone. The bench covers these with directed runs and a long randomized mix checked against its own model.

// File: rtl/tt_pkg.sv
package tt_pkg;
    localparam int TT_W      = 16;
    localparam int TT_RES_W  = 3;
    localparam int TT_MAXLOG = 6;

    typedef struct packed {
        logic [TT_W-1:0] cap;
        logic            vld;
        logic            stat;
    } tt_evt_s;
endpackage

// File: rtl/tt_prescaler.sv
module tt_prescaler #(
    parameter int RES_W  = 3,
    parameter int MAXLOG = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             us_tick_i,
    input  logic [RES_W-1:0] res_sel_i,
    output logic             tick_o
);
    localparam int PW = MAXLOG;

    typedef struct packed {
        logic [RES_W-1:0] res;
        logic [PW-1:0]    cnt;
    } pre_s;

    pre_s pre_d, pre_q;
    logic [PW-1:0] last_w;

    // terminal count: low 'shift' bits set, shift = code+1 capped at MAXLOG
    always_comb begin
        int shift;
        if (int'(res_sel_i) < MAXLOG) shift = int'(res_sel_i) + 1;
        else                          shift = MAXLOG;
        for (int i = 0; i < PW; i++) last_w[i] = (i < shift);
    end

    always_comb begin
        pre_d  = pre_q;
        tick_o = 1'b0;
        if (res_sel_i != pre_q.res) begin
            pre_d.res = res_sel_i;
            pre_d.cnt = '0;
        end else if (us_tick_i) begin
            if (pre_q.cnt >= last_w) begin
                pre_d.cnt = '0;
                tick_o    = 1'b1;
            end else begin
                pre_d.cnt = pre_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_d;
    end
endmodule

// File: rtl/tt_counter_core.sv
module tt_counter_core #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         host_wr_i,
    input  logic [W-1:0] host_wdata_i,
    input  logic         do_clr_i,
    input  logic         do_load_i,
    input  logic [W-1:0] load_data_i,
    input  logic         inc_i,
    output logic [W-1:0] count_o,
    output logic         wrap_o
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d  = cnt_q;
        wrap_o = 1'b0;
        if (host_wr_i)      cnt_d = host_wdata_i;
        else if (do_clr_i)  cnt_d = '0;
        else if (do_load_i) cnt_d = load_data_i;
        else if (inc_i) begin
            cnt_d  = cnt_q + 1'b1;
            wrap_o = &cnt_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign count_o = cnt_q;
endmodule

// File: rtl/tt_event_regs.sv
module tt_event_regs
    import tt_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            msg_done_i,
    input  logic [TT_W-1:0] count_i,
    input  logic            wrap_i,
    input  logic            roll_en_i,
    input  logic            stat_clr_i,
    input  logic            irq_mask_i,
    output logic [TT_W-1:0] capture_o,
    output logic            capture_vld_o,
    output logic            roll_stat_o,
    output logic            irq_o
);
    tt_evt_s ev_d, ev_q;

    always_comb begin
        ev_d     = ev_q;
        ev_d.vld = msg_done_i;
        if (msg_done_i) ev_d.cap = count_i;
        if (wrap_i && roll_en_i) ev_d.stat = 1'b1;
        else if (stat_clr_i)     ev_d.stat = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ev_q <= '0;
        else        ev_q <= ev_d;
    end

    assign capture_o     = ev_q.cap;
    assign capture_vld_o = ev_q.vld;
    assign roll_stat_o   = ev_q.stat;
    assign irq_o         = ev_q.stat & irq_mask_i;
endmodule

// File: rtl/time_tag_unit.sv
module time_tag_unit
    import tt_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                us_tick_i,
    input  logic [TT_RES_W-1:0] res_sel_i,
    input  logic                sw_mode_i,
    input  logic                sw_step_i,
    input  logic                host_wr_i,
    input  logic [TT_W-1:0]     host_wdata_i,
    input  logic                sync_clr_i,
    input  logic                clr_en_i,
    input  logic                sync_load_i,
    input  logic                load_en_i,
    input  logic [TT_W-1:0]     sync_data_i,
    input  logic                msg_done_i,
    input  logic                roll_en_i,
    input  logic                stat_clr_i,
    input  logic                irq_mask_i,
    output logic [TT_W-1:0]     count_o,
    output logic [TT_W-1:0]     capture_o,
    output logic                capture_vld_o,
    output logic                roll_stat_o,
    output logic                irq_o
);
    logic tick_w, inc_w, wrap_w;

    tt_prescaler #(.RES_W(TT_RES_W), .MAXLOG(TT_MAXLOG)) u_pre (
        .clk       (clk),
        .rst_n     (rst_n),
        .us_tick_i (us_tick_i),
        .res_sel_i (res_sel_i),
        .tick_o    (tick_w)
    );

    assign inc_w = sw_mode_i ? sw_step_i : tick_w;

    tt_counter_core #(.W(TT_W)) u_core (
        .clk          (clk),
        .rst_n        (rst_n),
        .host_wr_i    (host_wr_i),
        .host_wdata_i (host_wdata_i),
        .do_clr_i     (sync_clr_i & clr_en_i),
        .do_load_i    (sync_load_i & load_en_i),
        .load_data_i  (sync_data_i),
        .inc_i        (inc_w),
        .count_o      (count_o),
        .wrap_o       (wrap_w)
    );

    tt_event_regs u_evt (
        .clk           (clk),
        .rst_n         (rst_n),
        .msg_done_i    (msg_done_i),
        .count_i       (count_o),
        .wrap_i        (wrap_w),
        .roll_en_i     (roll_en_i),
        .stat_clr_i    (stat_clr_i),
        .irq_mask_i    (irq_mask_i),
        .capture_o     (capture_o),
        .capture_vld_o (capture_vld_o),
        .roll_stat_o   (roll_stat_o),
        .irq_o         (irq_o)
    );
endmodule

// File: rtl/tt_checker.sv
module tt_checker #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         host_wr_i,
    input logic [W-1:0] host_wdata_i,
    input logic         sw_mode_i,
    input logic         sw_step_i,
    input logic         sync_clr_i,
    input logic         clr_en_i,
    input logic         sync_load_i,
    input logic         load_en_i,
    input logic         msg_done_i,
    input logic         roll_en_i,
    input logic         stat_clr_i,
    input logic         irq_mask_i,
    input logic [W-1:0] count_o,
    input logic [W-1:0] capture_o,
    input logic         capture_vld_o,
    input logic         roll_stat_o,
    input logic         irq_o,
    input logic         wrap_w
);
    // R4
    host_write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_wr_i |=> count_o == $past(host_wdata_i));

    // R8
    capture_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        msg_done_i |=> (capture_vld_o && capture_o == $past(count_o)));

    // R10
    status_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (roll_stat_o && !stat_clr_i) |=> roll_stat_o);

    // R11
    irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_mask_i || !roll_stat_o) |-> !irq_o);

    // R9
    wrap_from_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_w |-> &count_o);

    // R9
    wrap_sets_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap_w && roll_en_i) |=> roll_stat_o);

    // R7
    sw_idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_mode_i && !sw_step_i && !host_wr_i && !(sync_clr_i && clr_en_i)
         && !(sync_load_i && load_en_i)) |=> count_o == $past(count_o));
endmodule

bind time_tag_unit tt_checker #(.W(tt_pkg::TT_W)) u_tt_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .host_wr_i     (host_wr_i),
    .host_wdata_i  (host_wdata_i),
    .sw_mode_i     (sw_mode_i),
    .sw_step_i     (sw_step_i),
    .sync_clr_i    (sync_clr_i),
    .clr_en_i      (clr_en_i),
    .sync_load_i   (sync_load_i),
    .load_en_i     (load_en_i),
    .msg_done_i    (msg_done_i),
    .roll_en_i     (roll_en_i),
    .stat_clr_i    (stat_clr_i),
    .irq_mask_i    (irq_mask_i),
    .count_o       (count_o),
    .capture_o     (capture_o),
    .capture_vld_o (capture_vld_o),
    .roll_stat_o   (roll_stat_o),
    .irq_o         (irq_o),
    .wrap_w        (wrap_w)
);

// File: tb/tb_time_tag_unit.sv
`timescale 1ns/1ps
module tb_time_tag_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        us_tick = 0, sw_mode = 0, sw_step = 0, host_wr = 0;
    logic [2:0]  res = 0;
    logic [15:0] wdata = 0, sdata = 0;
    logic        sclr = 0, clr_en = 0, sload = 0, load_en = 0;
    logic        msg_done = 0, roll_en = 0, stat_clr = 0, mask = 0;
    logic [15:0] count, cap;
    logic        cap_vld, stat, irq;

    int checks = 0, errors = 0, cycles = 0;

    // bench model state
    logic [2:0]  m_res = 0;
    int          m_pre = 0;
    logic [15:0] m_cnt = 0, m_cap = 0;
    logic        m_vld = 0, m_stat = 0;

    always #5 clk = ~clk;

    time_tag_unit dut (
        .clk(clk), .rst_n(rst_n), .us_tick_i(us_tick), .res_sel_i(res),
        .sw_mode_i(sw_mode), .sw_step_i(sw_step), .host_wr_i(host_wr),
        .host_wdata_i(wdata), .sync_clr_i(sclr), .clr_en_i(clr_en),
        .sync_load_i(sload), .load_en_i(load_en), .sync_data_i(sdata),
        .msg_done_i(msg_done), .roll_en_i(roll_en), .stat_clr_i(stat_clr),
        .irq_mask_i(mask), .count_o(count), .capture_o(cap),
        .capture_vld_o(cap_vld), .roll_stat_o(stat), .irq_o(irq)
    );

    function automatic int period_of(input logic [2:0] c);
        return (c > 3'd5) ? 64 : (2 << c);
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic model_step();
        bit tick = 0, inc, wrap;
        if (res != m_res) begin m_res = res; m_pre = 0; end
        else if (us_tick) begin
            if (m_pre == period_of(m_res) - 1) begin m_pre = 0; tick = 1; end
            else m_pre++;
        end
        inc  = sw_mode ? sw_step : tick;
        wrap = 0;
        m_vld = msg_done;
        if (msg_done) m_cap = m_cnt;
        if (host_wr)               m_cnt = wdata;
        else if (sclr && clr_en)   m_cnt = 0;
        else if (sload && load_en) m_cnt = sdata;
        else if (inc) begin wrap = (m_cnt == 16'hFFFF); m_cnt = m_cnt + 1; end
        if (wrap && roll_en) m_stat = 1;
        else if (stat_clr)   m_stat = 0;
    endtask

    task automatic compare_all();
        check(count == m_cnt, "R4 count", count, m_cnt);
        check(cap == m_cap, "R8 capture", cap, m_cap);
        check(cap_vld == m_vld, "R8 capture_vld", cap_vld, m_vld);
        check(stat == m_stat, "R9 status", stat, m_stat);
        check(irq == (m_stat & mask), "R11 irq", irq, m_stat & mask);
    endtask

    task automatic cyc();
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare_all();
    endtask

    task automatic idle_inputs();
        us_tick = 0; sw_step = 0; host_wr = 0; sclr = 0; sload = 0;
        msg_done = 0; stat_clr = 0;
    endtask

    // measure clocks from a fresh write of zero until the first increment
    task automatic measure(input logic [2:0] code, output int n);
        idle_inputs(); sw_mode = 0; res = code; host_wr = 1; wdata = 0;
        cyc();
        host_wr = 0; us_tick = 1; n = 0;
        while (count == 0 && n < 200) begin cyc(); n++; end
        us_tick = 0;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int n;
        void'($urandom(32'h1234_5678));
        repeat (3) @(negedge clk);
        // R1: reset state
        check(count == 0 && cap == 0 && !cap_vld && !stat && !irq, "R1 reset", count, 0);
        rst_n = 1;
        cyc();
        check(count == 0 && !stat && !irq, "R1 after reset", count, 0);

        // R2: each resolution code
        for (int c = 0; c < 8; c++) begin
            measure(c[2:0], n);
            check(n == period_of(c[2:0]), $sformatf("R2 code %0d period", c), n, period_of(c[2:0]));
        end

        // R3: restart on resolution change
        idle_inputs(); res = 3'd2; host_wr = 1; wdata = 0; cyc();
        host_wr = 0; us_tick = 1; repeat (5) cyc();
        us_tick = 0; res = 3'd1; cyc();
        us_tick = 1; n = 0;
        while (count == 0 && n < 200) begin cyc(); n++; end
        check(n == 4, "R3 restart period", n, 4);

        // R4: host write beats sync and tick
        idle_inputs(); sw_mode = 1; sw_step = 1; host_wr = 1; wdata = 16'hA5A5;
        sclr = 1; clr_en = 1; sload = 1; load_en = 1; sdata = 16'h1111;
        cyc();
        check(count == 16'hA5A5, "R4 priority", count, 16'hA5A5);

        // R5: sync clear enabled / disabled
        idle_inputs(); sclr = 1; clr_en = 0; cyc();
        check(count == 16'hA5A5, "R5 clear disabled", count, 16'hA5A5);
        sclr = 1; clr_en = 1; cyc();
        check(count == 0, "R5 clear enabled", count, 0);

        // R6: sync load enabled / disabled, clear beats load
        idle_inputs(); sload = 1; load_en = 0; sdata = 16'h3C3C; cyc();
        check(count == 0, "R6 load disabled", count, 0);
        load_en = 1; cyc();
        check(count == 16'h3C3C, "R6 load enabled", count, 16'h3C3C);
        sclr = 1; clr_en = 1; sload = 1; sdata = 16'h7777; cyc();
        check(count == 0, "R6 clear over load", count, 0);

        // R7: software mode ignores timed ticks
        idle_inputs(); sw_mode = 1; res = 0; us_tick = 1; repeat (20) cyc();
        check(count == 0, "R7 ticks ignored", count, 0);
        repeat (5) begin sw_step = 1; cyc(); sw_step = 0; cyc(); end
        check(count == 5, "R7 five steps", count, 5);

        // R8: capture
        idle_inputs(); msg_done = 1; cyc(); msg_done = 0;
        check(cap == 5 && cap_vld, "R8 capture set", cap, 5);
        cyc();
        check(!cap_vld, "R8 pulse ends", cap_vld, 0);

        // R9: rollover with and without enable
        idle_inputs(); roll_en = 0; host_wr = 1; wdata = 16'hFFFF; cyc();
        host_wr = 0; sw_step = 1; cyc(); sw_step = 0;
        check(count == 0 && !stat, "R9 disabled no status", stat, 0);
        host_wr = 1; wdata = 16'hFFFF; cyc(); host_wr = 0;
        roll_en = 1; sw_step = 1; cyc(); sw_step = 0;
        check(stat, "R9 status set", stat, 1);

        // R11: mask gating
        mask = 0; #1; check(!irq, "R11 masked", irq, 0);
        mask = 1; #1; check(irq, "R11 unmasked", irq, 1);

        // R10: sticky, clear, and set-beats-clear
        repeat (3) cyc();
        check(stat, "R10 sticky", stat, 1);
        stat_clr = 1; cyc(); stat_clr = 0;
        check(!stat, "R10 cleared", stat, 0);
        host_wr = 1; wdata = 16'hFFFF; cyc(); host_wr = 0;
        sw_step = 1; stat_clr = 1; cyc(); sw_step = 0; stat_clr = 0;
        check(stat, "R10 set beats clear", stat, 1);
        stat_clr = 1; cyc(); stat_clr = 0;

        // R12: zero via write or sync never sets status
        host_wr = 1; wdata = 16'hFFFF; cyc();
        wdata = 16'h0000; cyc(); host_wr = 0;
        check(!stat, "R12 host write to zero", stat, 0);
        host_wr = 1; wdata = 16'hFFFF; cyc(); host_wr = 0;
        sclr = 1; clr_en = 1; sw_step = 1; cyc(); sclr = 0; sw_step = 0;
        check(!stat && count == 0, "R12 sync clear to zero", stat, 0);

        // constrained random mix
        for (int i = 0; i < 6000; i++) begin
            us_tick  = ($urandom % 2) == 0;
            sw_step  = ($urandom % 5) == 0;
            host_wr  = ($urandom % 60) == 0;
            wdata    = ($urandom % 2) ? (16'hFFF0 | 16'($urandom % 16)) : 16'($urandom);
            sclr     = ($urandom % 40) == 0;
            sload    = ($urandom % 40) == 0;
            sdata    = ($urandom % 2) ? 16'hFFFE : 16'($urandom);
            msg_done = ($urandom % 8) == 0;
            stat_clr = ($urandom % 30) == 0;
            if (($urandom % 100) == 0) res = 3'($urandom);
            if (($urandom % 150) == 0) sw_mode = ~sw_mode;
            if (($urandom % 50) == 0) begin
                clr_en = $urandom; load_en = $urandom; roll_en = $urandom; mask = $urandom;
            end
            cyc();
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule